// File: doc/BRIEF.md
# Startup Overvoltage Guard for a Synchronous Buck Gate Driver

This block sits between the dead-time sequencer of a two-switch synchronous buck driver and the final gate outputs. Its input is a synchronized flag that goes high when the switch node is above the overvoltage threshold. When the block is armed and that flag holds for a set number of consecutive cycles, it latches a fault. The fault forces the low-side drive on, which clamps the switch node to ground, and forces the high-side drive off. While no fault is held, the sequencer's drive requests pass straight through.

Protection is armed only after input activity has been seen: either the PWM input or the active-low disable input sampled high at least once. This stops the block from tripping falsely while the controller is still powering up. Nothing on the logic inputs clears the arm latch or the fault latch. Only the supply undervoltage-lockout flag clears them. While that flag is high, both drives are held low.

Top module: `ovp_guard`

## Requirements
- R1: While `rst` or `uvlo` is high, `hs_drive` and `ls_drive` are both 0, whatever the requests and the fault state.
- R2: While no fault is latched, `hs_drive` equals `hs_req` and `ls_drive` equals `ls_req`, including when both requests are 1.
- R3: Before any input activity has been seen, `ov_flag` held high for any number of cycles does not set `fault`.
- R4: Once the block is armed, `ov_flag` must be sampled high on OV_FILT (default 2) consecutive clock edges. `fault` reads 1 after the last of those edges. A single-cycle pulse does not trip.
- R5: While `fault` is 1 and `uvlo` is 0, `hs_drive` is 0 and `ls_drive` is 1.
- R6: Once set, `fault` stays 1 while `uvlo` is 0, regardless of `pwm_in`, `dis_n`, the requests or `ov_flag` returning low.
- R7: A clock edge with `uvlo` high clears `fault` and the arm latch. After `uvlo` falls, the block must see input activity again before `ov_flag` can trip it.
- R8: The arm latch stays set after `pwm_in` and `dis_n` both return low.
- R9: A high level on `dis_n` alone, with `pwm_in` low, arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command input (observed for arming) |
| dis_n | input | 1 | Active-low output disable input (observed for arming) |
| ov_flag | input | 1 | Synchronized switch-node overvoltage flag |
| uvlo | input | 1 | Supply undervoltage lockout, active high |
| hs_req | input | 1 | High-side drive request from the sequencer |
| ls_req | input | 1 | Low-side drive request from the sequencer |
| hs_drive | output | 1 | Final high-side gate drive |
| ls_drive | output | 1 | Final low-side gate drive |
| fault | output | 1 | Latched overvoltage fault status |

## Verification
The pass-through path is tried with all four request combinations, each under a different pattern of PWM and disable levels. This shows that arming has no effect on the outputs while no fault is held. The overvoltage flag is applied in four situations: long before any activity, as a one-cycle glitch, as a two-cycle run after arming by PWM, and as a run after arming by the disable input alone. Together these separate a missing arm gate, a missing filter and a wrong arming source. After a trip, every input is toggled to show the latch is sticky. Then a lockout pulse followed by more overvoltage with no activity shows that both latches were cleared.

// File: rtl/ovp_guard_pkg.sv
package ovp_guard_pkg;

    typedef struct packed {
        logic hs;
        logic ls;
    } drive_t;

    typedef struct packed {
        logic armed;
        logic tripped;
    } guard_state_t;

    // Final gate levels from the requests, the latched fault and the force-off condition
    function automatic drive_t resolve_drive(drive_t req, logic tripped, logic force_off);
        drive_t d;
        if (force_off) begin
            d.hs = 1'b0;
            d.ls = 1'b0;
        end else if (tripped) begin
            d.hs = 1'b0;
            d.ls = 1'b1;
        end else begin
            d = req;
        end
        return d;
    endfunction

endpackage

// File: rtl/ovp_arm_latch.sv
module ovp_arm_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic activity,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            armed <= 1'b0;
        else if (activity)
            armed <= 1'b1;
    end
endmodule

// File: rtl/ovp_glitch_filter.sv
module ovp_glitch_filter #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flag,
    output logic qualified
);
    localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    generate
        if (DEPTH <= 1) begin : g_direct
            assign qualified = flag;
        end else begin : g_count
            logic [CW-1:0] run_q;
            always_ff @(posedge clk) begin
                if (rst || clr || !flag)
                    run_q <= '0;
                else if (run_q != LAST)
                    run_q <= run_q + 1'b1;
            end
            assign qualified = flag && (run_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ovp_fault_latch.sv
module ovp_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic armed,
    input  logic ov_ok,
    output logic tripped
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            tripped <= 1'b0;
        else if (armed && ov_ok)
            tripped <= 1'b1;
    end
endmodule

// File: rtl/ovp_guard.sv
module ovp_guard
    import ovp_guard_pkg::*;
#(
    parameter int OV_FILT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic dis_n,
    input  logic ov_flag,
    input  logic uvlo,
    input  logic hs_req,
    input  logic ls_req,
    output logic hs_drive,
    output logic ls_drive,
    output logic fault
);
    guard_state_t st;
    logic         ov_ok;
    drive_t       req;
    drive_t       drv;

    ovp_arm_latch u_arm (
        .clk      (clk),
        .rst      (rst),
        .clr      (uvlo),
        .activity (pwm_in | dis_n),
        .armed    (st.armed)
    );

    ovp_glitch_filter #(.DEPTH(OV_FILT)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .clr       (uvlo),
        .flag      (ov_flag),
        .qualified (ov_ok)
    );

    ovp_fault_latch u_flt (
        .clk     (clk),
        .rst     (rst),
        .clr     (uvlo),
        .armed   (st.armed),
        .ov_ok   (ov_ok),
        .tripped (st.tripped)
    );

    assign req.hs   = hs_req;
    assign req.ls   = ls_req;
    assign drv      = resolve_drive(req, st.tripped, rst | uvlo);
    assign hs_drive = drv.hs;
    assign ls_drive = drv.ls;
    assign fault    = st.tripped;
endmodule

// File: rtl/ovp_guard_chk.sv
module ovp_guard_chk (
    input logic clk,
    input logic rst,
    input logic ov_flag,
    input logic uvlo,
    input logic hs_req,
    input logic ls_req,
    input logic hs_drive,
    input logic ls_drive,
    input logic fault,
    input logic armed
);
    // R1
    lockout_low_chk: assert property (@(posedge clk) disable iff (rst)
        uvlo |-> (!hs_drive && !ls_drive));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!fault && !uvlo) |-> (hs_drive == hs_req && ls_drive == ls_req));

    // R3
    armed_before_trip_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(armed));

    // R4
    filtered_trip_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> ($past(ov_flag, 1) && $past(ov_flag, 2)));

    // R5
    fault_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !uvlo) |-> (ls_drive && !hs_drive));

    // R6
    sticky_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !uvlo) |=> fault);

    // R7
    lockout_clear_chk: assert property (@(posedge clk) disable iff (rst)
        uvlo |=> (!fault && !armed));
endmodule

bind ovp_guard ovp_guard_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ov_flag  (ov_flag),
    .uvlo     (uvlo),
    .hs_req   (hs_req),
    .ls_req   (ls_req),
    .hs_drive (hs_drive),
    .ls_drive (ls_drive),
    .fault    (fault),
    .armed    (st.armed)
);

// File: tb/ovp_guard_test.sv
`timescale 1ns/1ps
module ovp_guard_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b0, dis_n = 1'b0, ov_flag = 1'b0, uvlo = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0;
    logic hs_drive, ls_drive, fault;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    ovp_guard #(.OV_FILT(2)) uut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .dis_n(dis_n), .ov_flag(ov_flag),
        .uvlo(uvlo), .hs_req(hs_req), .ls_req(ls_req),
        .hs_drive(hs_drive), .ls_drive(ls_drive), .fault(fault)
    );

    // {pwm_in, dis_n, hs_req, ls_req, exp_hs, exp_ls}
    localparam logic [5:0] VEC [8] = '{
        6'b00_00_00, 6'b00_10_10, 6'b10_01_01, 6'b01_11_11,
        6'b11_10_10, 6'b01_00_00, 6'b10_11_11, 6'b00_01_01
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {hs,ls,fault} actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        hs_req = 1'b1; ls_req = 1'b1;
        repeat (3) tick();
        #1 chk("R1 reset", {hs_drive, ls_drive, fault}, 3'b000);
        rst = 1'b0; hs_req = 1'b1; ls_req = 1'b0;
        tick();

        // R3: overvoltage long before any activity
        ov_flag = 1'b1;
        repeat (5) tick();
        #1 chk("R3 unarmed", {hs_drive, ls_drive, fault}, 3'b100);
        ov_flag = 1'b0;
        tick();

        // R2: pass-through table (also arms via activity)
        for (int i = 0; i < 8; i++) begin
            {pwm_in, dis_n, hs_req, ls_req} = VEC[i][5:2];
            #1 chk("R2 pass", {hs_drive, ls_drive, fault}, {VEC[i][1:0], 1'b0});
            tick();
        end
        pwm_in = 1'b0; dis_n = 1'b0; hs_req = 1'b1; ls_req = 1'b0;
        tick();

        // R4: one-cycle glitch does not trip
        ov_flag = 1'b1;
        tick();
        ov_flag = 1'b0;
        tick(); tick();
        #1 chk("R4 glitch", {hs_drive, ls_drive, fault}, 3'b100);

        // R4, R8: two consecutive samples trip with inputs idle
        ov_flag = 1'b1;
        tick();
        #1 chk("R4 first sample", {hs_drive, ls_drive, fault}, 3'b100);
        tick();
        #1 chk("R8 R5 trip", {hs_drive, ls_drive, fault}, 3'b011);

        // R6: sticky under activity
        ov_flag = 1'b0;
        for (int i = 0; i < 6; i++) begin
            pwm_in = i[0]; dis_n = i[1]; hs_req = ~i[0]; ls_req = i[2];
            tick();
            #1 chk("R6 sticky", {hs_drive, ls_drive, fault}, 3'b011);
        end
        pwm_in = 1'b0; dis_n = 1'b0; hs_req = 1'b1; ls_req = 1'b1;

        // R1: lockout forces drives low at once
        uvlo = 1'b1;
        #1 chk("R1 uvlo", {hs_drive, ls_drive, fault}, 3'b001);
        tick();
        #1 chk("R7 clear", {hs_drive, ls_drive, fault}, 3'b000);
        uvlo = 1'b0; hs_req = 1'b0; ls_req = 1'b1;
        tick();

        // R7: arm cleared, overvoltage alone cannot trip
        ov_flag = 1'b1;
        repeat (4) tick();
        #1 chk("R7 disarmed", {hs_drive, ls_drive, fault}, 3'b010);
        ov_flag = 1'b0;
        tick();

        // R9: arm via disable input only
        dis_n = 1'b1;
        tick();
        dis_n = 1'b0; ov_flag = 1'b1;
        tick();
        #1 chk("R9 first", {hs_drive, ls_drive, fault}, 3'b010);
        tick();
        #1 chk("R9 trip", {hs_drive, ls_drive, fault}, 3'b011);
        ov_flag = 1'b0;
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule